// File: doc/BRIEF.md
# Error Signaling Aggregator

The block gathers single-cycle error pulses from three groups of channels, each group one severity level, and turns them into sticky status bits and two interrupt requests. Every channel has its own status bit. Software reads it over a simple register bus and clears it by writing a one to that bit. Each incoming pulse first passes through a capture register. The status bit then sets on the next clock.

Low-severity channels feed a low-priority interrupt, gated by a per-channel enable that software owns. Software may turn every enable off and still poll the status bits to log events. High-severity channels feed the high-priority interrupt line, and no enable can block it. An interrupt controller normally turns that line into a fast interrupt for the CPU. Top-severity channels only record status, because their faults reach the CPU by another path.

Top module: `err_sig_aggr`

## Requirements
- R1: After reset, every readable register reads zero, and both `irq_lo_o` and `irq_hi_o` are low.
- R2: A one-cycle pulse on an error input bit sets the matching status bit. The bit is readable from the second rising edge after the pulse was sampled.
- R3: A status bit stays set until a bus write to that group's status word carries a one in that bit position. Writing zero bits leaves the status unchanged.
- R4: If an error pulse is presented in the cycle just before a clearing write to the same bit, the bit stays set. Other bits cleared by that write still clear.
- R5: The low-severity enable word is read/write at word address 0. `irq_lo_o` is high exactly when some bit is set in both the low-severity status word and the enable word.
- R6: A low-severity pulse sets its status bit even when its enable bit is zero. In that case `irq_lo_o` stays low.
- R7: Any high-severity pulse drives `irq_hi_o` high two rising edges after it is sampled, whatever the enable word holds. The line falls once every high-severity status bit is cleared.
- R8: Top-severity pulses set status bits but never raise `irq_lo_o` or `irq_hi_o`.
- R9: Word address 4 reads the low-severity pending word, which is status AND enable. Writes to it are ignored.
- R10: Status words sit at word addresses 1 (low), 2 (high) and 3 (top). Read data appears on `bus_rdata_o` one rising edge after the read strobe. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| err_g1_i | input | NUM_CH | Low-severity error pulses |
| err_g2_i | input | NUM_CH | High-severity error pulses |
| err_g3_i | input | NUM_CH | Top-severity error pulses |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | NUM_CH | Write data |
| bus_rdata_o | output | NUM_CH | Registered read data |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| irq_hi_o | output | 1 | High-priority interrupt request |

## Verification
The bench sends an error pulse one cycle before a clearing write to the same bit. A design where clear beats set would drop that event without any trace. It raises a high-severity pulse while every enable is zero, which exposes a design that masks the high line through the enable word. It also sends top-severity pulses with all enables set, which catches a top group wired into either interrupt. Further checks write ones to the pending word and write zeros to a status word, and these catch a design that lets a read-only word or a zero bit change state.

// File: rtl/err_sig_aggr_pkg.sv
package err_sig_aggr_pkg;
  localparam int unsigned NUM_GROUPS = 3;
  localparam int unsigned GRP_LO  = 0;
  localparam int unsigned GRP_HI  = 1;
  localparam int unsigned GRP_TOP = 2;

  localparam int unsigned ADDR_EN_LO   = 0;
  localparam int unsigned ADDR_ST_LO   = 1;
  localparam int unsigned ADDR_ST_HI   = 2;
  localparam int unsigned ADDR_ST_TOP  = 3;
  localparam int unsigned ADDR_PEND_LO = 4;
endpackage

// File: rtl/esa_rst_sync.sv
module esa_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/esa_capture.sv
module esa_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] err_i,
  output logic [W-1:0] cap_o
);
  logic [W-1:0] cap_q;
  logic         cap_en;

  // Only toggle the register when something is or was present.
  assign cap_en = (|err_i) | (|cap_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cap_q <= '0;
    else if (cap_en) cap_q <= err_i;
  end

  assign cap_o = cap_q;
endmodule

// File: rtl/esa_status_bank.sv
module esa_status_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cap_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_mask_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;
  logic [W-1:0] clr_eff;
  logic         st_en;

  always_comb begin
    clr_eff = clr_en_i ? clr_mask_i : '0;
    // A captured event in the same cycle outranks the clear.
    st_d    = (st_q & ~clr_eff) | cap_i;
    st_en   = clr_en_i | (|cap_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status_o = st_q;
endmodule

// File: rtl/esa_regif.sv
module esa_regif
  import err_sig_aggr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_rd_i,
  input  logic                  bus_wr_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [NUM_CH-1:0]     bus_wdata_i,
  input  logic [NUM_CH-1:0]     st_lo_i,
  input  logic [NUM_CH-1:0]     st_hi_i,
  input  logic [NUM_CH-1:0]     st_top_i,
  input  logic [NUM_CH-1:0]     pend_lo_i,
  output logic [NUM_CH-1:0]     en_lo_o,
  output logic [NUM_GROUPS-1:0] clr_o,
  output logic [NUM_CH-1:0]     rdata_o
);
  logic [NUM_CH-1:0] en_q, en_d;
  logic              en_we;
  logic [NUM_CH-1:0] rd_mux;
  logic [NUM_CH-1:0] rdata_q;
  logic              hit_en, hit_lo, hit_hi, hit_top;

  always_comb begin
    hit_en  = (bus_addr_i == ADDR_W'(ADDR_EN_LO));
    hit_lo  = (bus_addr_i == ADDR_W'(ADDR_ST_LO));
    hit_hi  = (bus_addr_i == ADDR_W'(ADDR_ST_HI));
    hit_top = (bus_addr_i == ADDR_W'(ADDR_ST_TOP));

    en_we = bus_wr_i & hit_en;
    en_d  = bus_wdata_i;

    clr_o          = '0;
    clr_o[GRP_LO]  = bus_wr_i & hit_lo;
    clr_o[GRP_HI]  = bus_wr_i & hit_hi;
    clr_o[GRP_TOP] = bus_wr_i & hit_top;

    case (bus_addr_i)
      ADDR_W'(ADDR_EN_LO):   rd_mux = en_q;
      ADDR_W'(ADDR_ST_LO):   rd_mux = st_lo_i;
      ADDR_W'(ADDR_ST_HI):   rd_mux = st_hi_i;
      ADDR_W'(ADDR_ST_TOP):  rd_mux = st_top_i;
      ADDR_W'(ADDR_PEND_LO): rd_mux = pend_lo_i;
      default:               rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign en_lo_o = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/err_sig_aggr.sv
module err_sig_aggr
  import err_sig_aggr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] err_g1_i,
  input  logic [NUM_CH-1:0] err_g2_i,
  input  logic [NUM_CH-1:0] err_g3_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NUM_CH-1:0] bus_wdata_i,
  output logic [NUM_CH-1:0] bus_rdata_o,
  output logic              irq_lo_o,
  output logic              irq_hi_o
);
  logic rst_n;
  logic [NUM_GROUPS-1:0][NUM_CH-1:0] err_in;
  logic [NUM_GROUPS-1:0][NUM_CH-1:0] cap;
  logic [NUM_GROUPS-1:0][NUM_CH-1:0] status;
  logic [NUM_GROUPS-1:0]             clr;
  logic [NUM_CH-1:0]                 en_lo;
  logic [NUM_CH-1:0]                 pend_lo;

  esa_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  assign err_in[GRP_LO]  = err_g1_i;
  assign err_in[GRP_HI]  = err_g2_i;
  assign err_in[GRP_TOP] = err_g3_i;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    esa_capture #(.W(NUM_CH)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .err_i  (err_in[g]),
      .cap_o  (cap[g])
    );
    esa_status_bank #(.W(NUM_CH)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .cap_i      (cap[g]),
      .clr_en_i   (clr[g]),
      .clr_mask_i (bus_wdata_i),
      .status_o   (status[g])
    );
  end

  assign pend_lo = status[GRP_LO] & en_lo;

  esa_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .st_lo_i     (status[GRP_LO]),
    .st_hi_i     (status[GRP_HI]),
    .st_top_i    (status[GRP_TOP]),
    .pend_lo_i   (pend_lo),
    .en_lo_o     (en_lo),
    .clr_o       (clr),
    .rdata_o     (bus_rdata_o)
  );

  // Top-severity status is deliberately left out of both requests.
  assign irq_lo_o = |pend_lo;
  assign irq_hi_o = |status[GRP_HI];
endmodule

// File: rtl/err_sig_aggr_chk.sv
module err_sig_aggr_chk
  import err_sig_aggr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [NUM_CH-1:0] err_g2_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [NUM_CH-1:0] bus_wdata_i,
  input logic [NUM_CH-1:0] en_lo,
  input logic [NUM_CH-1:0] st_lo,
  input logic [NUM_CH-1:0] cap_lo,
  input logic              irq_lo_o,
  input logic              irq_hi_o
);
  logic wr_st_lo;
  assign wr_st_lo = bus_wr_i && (bus_addr_i == ADDR_W'(ADDR_ST_LO));

  p_hi_unmasked_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (|err_g2_i) |-> ##2 irq_hi_o);

  p_lo_needs_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_lo_o |-> (en_lo != '0));

  p_lo_off_when_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (en_lo == '0) |-> !irq_lo_o);

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_st_lo |=> ((st_lo & $past(st_lo)) == $past(st_lo)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_st_lo |=> ((st_lo & $past(bus_wdata_i & ~cap_lo)) == '0));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cap_lo != '0) |=> ((st_lo & $past(cap_lo)) == $past(cap_lo)));
endmodule

bind err_sig_aggr err_sig_aggr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .err_g2_i    (err_g2_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .en_lo       (en_lo),
  .st_lo       (status[0]),
  .cap_lo      (cap[0]),
  .irq_lo_o    (irq_lo_o),
  .irq_hi_o    (irq_hi_o)
);

// File: tb/err_sig_aggr_tb.sv
`timescale 1ns/1ps
module err_sig_aggr_tb;
  localparam int NCH = 32;
  localparam int AW  = 3;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [NCH-1:0] err_g1_i = '0, err_g2_i = '0, err_g3_i = '0;
  logic           bus_rd_i = 1'b0, bus_wr_i = 1'b0;
  logic [AW-1:0]  bus_addr_i = '0;
  logic [NCH-1:0] bus_wdata_i = '0;
  logic [NCH-1:0] bus_rdata_o;
  logic           irq_lo_o, irq_hi_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [NCH-1:0] exp;
    string          tag;
  } exp_item_t;
  exp_item_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  err_sig_aggr #(.NUM_CH(NCH), .ADDR_W(AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .err_g1_i(err_g1_i), .err_g2_i(err_g2_i), .err_g3_i(err_g3_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_lo_o(irq_lo_o), .irq_hi_o(irq_hi_o)
  );

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issue a read and queue the value the requirements predict.
  task automatic rd(input int addr, input logic [NCH-1:0] exp, input string tag);
    exp_item_t it;
    @(negedge clk_i);
    bus_rd_i   = 1'b1;
    bus_addr_i = AW'(addr);
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
    bus_rd_i = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [NCH-1:0] data);
    @(negedge clk_i);
    bus_wr_i    = 1'b1;
    bus_addr_i  = AW'(addr);
    bus_wdata_i = data;
    @(negedge clk_i);
    bus_wr_i    = 1'b0;
    bus_wdata_i = '0;
  endtask

  // One-cycle pulse; returns at the negedge after capture, status sets one edge later.
  task automatic pulse(input int grp, input logic [NCH-1:0] m);
    @(negedge clk_i);
    if (grp == 1) err_g1_i = m;
    if (grp == 2) err_g2_i = m;
    if (grp == 3) err_g3_i = m;
    @(negedge clk_i);
    err_g1_i = '0; err_g2_i = '0; err_g3_i = '0;
  endtask

  // Monitor: pop and compare as read data emerges.
  initial begin
    forever begin
      @(posedge clk_i);
      if (bus_rd_i === 1'b1) begin
        exp_item_t it;
        @(negedge clk_i);
        if (sb_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R10 unexpected read actual=%h expected=none", bus_rdata_o);
        end else begin
          it = sb_q.pop_front();
          check(it.tag, bus_rdata_o, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 reset state
    check("R1 irq_lo", NCH'(irq_lo_o), '0);
    check("R1 irq_hi", NCH'(irq_hi_o), '0);
    for (int a = 0; a < 5; a++) rd(a, '0, "R1 reset read");
    rd(6, '0, "R10 unmapped");

    // R6/R2: low-severity event with enables off
    pulse(1, 32'h0000_0020);
    @(negedge clk_i);
    check("R6 irq_lo masked", NCH'(irq_lo_o), '0);
    rd(1, 32'h0000_0020, "R2 R6 status lo");

    // R5 enable
    wr(0, 32'h0000_0020);
    check("R5 irq_lo enabled", NCH'(irq_lo_o), 1);
    rd(0, 32'h0000_0020, "R5 enable readback");
    rd(4, 32'h0000_0020, "R9 pending");
    wr(4, '1);
    rd(4, 32'h0000_0020, "R9 pending write ignored");

    // R3 clear behaviour
    wr(1, 32'h0000_0000);
    rd(1, 32'h0000_0020, "R3 zero write keeps");
    wr(1, 32'h0000_0020);
    rd(1, 32'h0000_0000, "R3 clear");
    check("R5 irq_lo after clear", NCH'(irq_lo_o), 0);

    // Multi-bit pattern
    pulse(1, 32'hA5A5_0001);
    @(negedge clk_i);
    rd(1, 32'hA5A5_0001, "R2 pattern");
    rd(4, 32'h0000_0000, "R9 pending masked");
    wr(1, '1);

    // R7 high-severity, enables all zero
    wr(0, '0);
    pulse(2, 32'h8000_0000);
    check("R7 irq_hi not yet", NCH'(irq_hi_o), 0);
    @(negedge clk_i);
    check("R7 irq_hi set", NCH'(irq_hi_o), 1);
    rd(2, 32'h8000_0000, "R10 status hi");
    wr(2, 32'h8000_0000);
    check("R7 irq_hi cleared", NCH'(irq_hi_o), 0);

    // R8 top severity with enables all set
    wr(0, '1);
    pulse(3, 32'h0000_0081);
    @(negedge clk_i);
    check("R8 irq_lo", NCH'(irq_lo_o), 0);
    check("R8 irq_hi", NCH'(irq_hi_o), 0);
    rd(3, 32'h0000_0081, "R8 status top");

    // R4 set wins over clear
    pulse(1, 32'h0000_0018);
    @(negedge clk_i);
    err_g1_i = 32'h0000_0008;
    @(negedge clk_i);
    err_g1_i    = '0;
    bus_wr_i    = 1'b1;
    bus_addr_i  = AW'(1);
    bus_wdata_i = 32'h0000_0018;
    @(negedge clk_i);
    bus_wr_i    = 1'b0;
    bus_wdata_i = '0;
    rd(1, 32'h0000_0008, "R4 set wins");
    check("R4 irq_lo still", NCH'(irq_lo_o), 1);

    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 pending reads actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule